// File: doc/BRIEF.md
# Host bridge register decoder

This block sits behind a 24-bit CPU register window of a PCI host bridge. Each request is decoded to one of three targets: the configuration address register, the four-byte configuration data port, or an interrupt-acknowledge read that fetches the pending vector from the interrupt controller. All other offsets are unimplemented. Accesses are 1 to 4 bytes wide and little-endian. Data is right-aligned on the CPU side and moved to its byte lane on the target side. The configuration targets and the interrupt controller sit outside this block. They are reached through plain strobe, byte-enable and read-data ports, and their read data is sampled in the cycle the request is presented.

The block also merges device interrupt requests onto the four interrupt lines of the bus. Two on-board positions are routed specially. Expansion slots, which start at slot 8, use the usual rotation by slot number. A request is answered one cycle after it is presented. A sideband flag marks accesses that hit nothing.

Top module: `hostbr_regdec`

## Requirements
- R1: Offset 0xC00CF8 (exact match) accesses the configuration address register. A read pulses `caddr_rd`, a write pulses `caddr_wr`, and `tgt_be` enables the lowest size+1 byte lanes. Offsets 0xC00CF9 to 0xC00CFB are unimplemented.
- R2: Offsets 0xE00CFC to 0xE00CFF access the configuration data port, with lane = address bits [1:0]. On a write, the CPU data bytes 0..size go to target lanes lane..lane+size, and `tgt_be` is ((1<<(size+1))-1)<<lane. On a read, target lane lane+k is returned as response byte k.
- R3: A data-port access whose lane+size exceeds 3 (it would run past 0xE00CFF) is unimplemented.
- R4: A read at 0xF00000 pulses `iack_rd` and returns the 8-bit vector zero-extended. A write to 0xF00000 is unimplemented and raises no strobe.
- R5: An unimplemented read returns 0xFFFFFFFF. An unimplemented write changes no target and raises no strobe. Both set `rsp_unimpl` in the response. At most one target strobe is active in any cycle.
- R6: `req_size` encodes bytes-1 (0 = 1 byte, 3 = 4 bytes). On an implemented read, response bytes above the access size are zero. Write data bytes above the size never reach a target.
- R7: `rsp_valid` is high for exactly one cycle, in the cycle after each cycle with `req_valid` high. `rsp_rdata` and `rsp_unimpl` belong to that request.
- R8: Each device position d has four request bits at indices d*4+pin (pin 0..3 = A..D). Position 0 is slot 6, which goes to line 3 for any pin. Position 1 is slot 7, which goes to line pin. Position 2+k is expansion slot 8+k, which goes to line (slot+pin) mod 4.
- R9: `irq_line` is the OR of all routed requests, registered, so it follows `irq_req` one cycle later.
- R10: During reset and in the cycles after it, `rsp_valid`, `rsp_rdata`, `rsp_unimpl` and `irq_line` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | CPU request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Offset inside the register window |
| req_size | input | 2 | Access bytes minus one |
| req_wdata | input | 32 | Right-aligned write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Right-aligned read data |
| rsp_unimpl | output | 1 | Request hit no implemented target |
| caddr_wr | output | 1 | Write strobe, configuration address register |
| caddr_rd | output | 1 | Read strobe, configuration address register |
| cdata_wr | output | 1 | Write strobe, configuration data port |
| cdata_rd | output | 1 | Read strobe, configuration data port |
| tgt_be | output | 4 | Byte enables toward the configuration targets |
| tgt_wdata | output | 32 | Lane-placed write data toward the targets |
| caddr_rdata | input | 32 | Address register contents |
| cdata_rdata | input | 32 | Data port contents |
| iack_rd | output | 1 | Interrupt-acknowledge strobe |
| iack_vec | input | 8 | Pending interrupt vector |
| irq_req | input | 20 | Device interrupt requests, four per position |
| irq_line | output | 4 | Routed interrupt lines |

## Verification
The interrupt merger and the register decoder can act in the same cycle. The key case is an acknowledge read or a data-port access that coincides with a change in device requests. The bench changes `irq_req` in the very cycle it presents each register access. At the next falling edge it judges both results: the response data and flag against a shadow model of the targets, and the line outputs against a routing function computed in the bench. A fault that couples the two paths, or mixes up lane placement with line routing, shows up as a miscompare on one side.

// File: rtl/hostbr_pkg.sv
package hostbr_pkg;

  typedef enum logic [1:0] {
    TGT_NONE  = 2'd0,
    TGT_CADDR = 2'd1,
    TGT_CDATA = 2'd2,
    TGT_IACK  = 2'd3
  } tgt_e;

  // Interrupt line for a device at a given slot and pin.
  function automatic int unsigned route_line(
    input int unsigned slot,
    input int unsigned pin,
    input int unsigned fixed_slot,
    input int unsigned pass_slot,
    input int unsigned fixed_line,
    input int unsigned lines
  );
    if (slot == fixed_slot) return fixed_line;
    else if (slot == pass_slot) return pin % lines;
    else return (slot + pin) % lines;
  endfunction

endpackage

// File: rtl/hostbr_decode.sv
module hostbr_decode
  import hostbr_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] CADDR_OFS = 24'hC00CF8,
  parameter logic [ADDR_W-1:0] CDATA_OFS = 24'hE00CFC,
  parameter logic [ADDR_W-1:0] IACK_OFS  = 24'hF00000
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            req_valid,
  input  logic                            req_write,
  input  logic [ADDR_W-1:0]               req_addr,
  input  logic [$clog2(DATA_W/8)-1:0]     req_size,
  output tgt_e                            tgt,
  output logic [DATA_W/8-1:0]             be
);

  localparam int unsigned BYTES  = DATA_W / 8;
  localparam int unsigned LANE_W = $clog2(BYTES);

  logic [LANE_W-1:0] lane;
  logic [BYTES-1:0]  size_be;
  logic [LANE_W:0]   span;
  logic              fits;
  logic              cdata_win;

  always_comb begin
    lane = req_addr[LANE_W-1:0];
    for (int b = 0; b < BYTES; b++) begin
      size_be[b] = (LANE_W'(b) <= req_size);
    end
    span      = {1'b0, lane} + {1'b0, req_size};
    fits      = (span < (LANE_W+1)'(BYTES));
    cdata_win = (req_addr[ADDR_W-1:LANE_W] == CDATA_OFS[ADDR_W-1:LANE_W]);

    tgt = TGT_NONE;
    be  = size_be;
    if (req_addr == CADDR_OFS) begin
      tgt = TGT_CADDR;
    end else if (cdata_win && fits) begin
      tgt = TGT_CDATA;
      be  = size_be << lane;
    end else if ((req_addr == IACK_OFS) && !req_write) begin
      tgt = TGT_IACK;
    end
  end

  // R2: the lane-shifted enables keep every byte of the access
  p_lane_bytes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && tgt == TGT_CDATA) |->
      ($countones(be) == int'(req_size) + 1) && be[lane]);

  // R3: an accepted data-port access never runs past the last lane
  p_no_overrun_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && tgt == TGT_CDATA) |-> (int'(lane) + int'(req_size) < BYTES));

endmodule

// File: rtl/hostbr_lanes.sv
module hostbr_lanes
  import hostbr_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned VEC_W  = 8
) (
  input  tgt_e                         tgt,
  input  logic                         req_write,
  input  logic [$clog2(DATA_W/8)-1:0]  lane,
  input  logic [$clog2(DATA_W/8)-1:0]  req_size,
  input  logic [DATA_W-1:0]            req_wdata,
  input  logic [DATA_W-1:0]            caddr_rdata,
  input  logic [DATA_W-1:0]            cdata_rdata,
  input  logic [VEC_W-1:0]             iack_vec,
  output logic [DATA_W-1:0]            bus_wdata,
  output logic [DATA_W-1:0]            rd_data
);

  localparam int unsigned BYTES  = DATA_W / 8;
  localparam int unsigned LANE_W = $clog2(BYTES);
  localparam int unsigned SHIFT_W = LANE_W + 3;

  logic [DATA_W-1:0]  dmask;
  logic [SHIFT_W-1:0] shamt;
  logic [DATA_W-1:0]  wmasked;

  always_comb begin
    for (int b = 0; b < BYTES; b++) begin
      dmask[b*8 +: 8] = {8{LANE_W'(b) <= req_size}};
    end
    shamt   = {lane, 3'b000};
    wmasked = req_wdata & dmask;

    if (tgt == TGT_CDATA) bus_wdata = wmasked << shamt;
    else                  bus_wdata = wmasked;

    if (req_write) begin
      rd_data = '0;
    end else begin
      unique case (tgt)
        TGT_CADDR: rd_data = caddr_rdata & dmask;
        TGT_CDATA: rd_data = (cdata_rdata >> shamt) & dmask;
        TGT_IACK:  rd_data = DATA_W'(iack_vec) & dmask;
        default:   rd_data = '1;
      endcase
    end
  end

endmodule

// File: rtl/hostbr_irqmap.sv
module hostbr_irqmap
  import hostbr_pkg::*;
#(
  parameter int unsigned NUM_EXP        = 3,
  parameter int unsigned FIRST_EXP_SLOT = 8,
  parameter int unsigned FIXED_SLOT     = 6,
  parameter int unsigned PASS_SLOT      = 7,
  parameter int unsigned FIXED_LINE     = 3,
  parameter int unsigned PINS           = 4,
  parameter int unsigned LINES          = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [(NUM_EXP+2)*PINS-1:0]    irq_req,
  output logic [LINES-1:0]               irq_line
);

  localparam int unsigned NDEV  = NUM_EXP + 2;
  localparam int unsigned REQ_W = NDEV * PINS;

  logic [LINES-1:0] onehot [REQ_W];
  logic [LINES-1:0] line_d;

  for (genvar d = 0; d < NDEV; d++) begin : g_dev
    localparam int unsigned SLOT = (d == 0) ? FIXED_SLOT :
                                   (d == 1) ? PASS_SLOT  :
                                   FIRST_EXP_SLOT + d - 2;
    for (genvar p = 0; p < PINS; p++) begin : g_pin
      localparam int unsigned LINE =
        route_line(SLOT, p, FIXED_SLOT, PASS_SLOT, FIXED_LINE, LINES);
      assign onehot[d*PINS+p] = irq_req[d*PINS+p] ?
        ({{(LINES-1){1'b0}}, 1'b1} << LINE) : '0;
    end
  end

  always_comb begin
    line_d = '0;
    for (int i = 0; i < REQ_W; i++) line_d = line_d | onehot[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_line <= '0;
    else        irq_line <= line_d;
  end

  // R9: no request, no line one cycle later
  p_quiet_lines_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req == '0) |=> (irq_line == '0));

  // R8: any pin of the fixed-line position drives that line
  p_fixed_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req[PINS-1:0] != '0) |=> irq_line[FIXED_LINE]);

endmodule

// File: rtl/hostbr_regdec.sv
module hostbr_regdec
  import hostbr_pkg::*;
#(
  parameter int unsigned ADDR_W         = 24,
  parameter int unsigned DATA_W         = 32,
  parameter int unsigned VEC_W          = 8,
  parameter int unsigned NUM_EXP        = 3,
  parameter int unsigned FIRST_EXP_SLOT = 8,
  parameter logic [ADDR_W-1:0] CADDR_OFS = 24'hC00CF8,
  parameter logic [ADDR_W-1:0] CDATA_OFS = 24'hE00CFC,
  parameter logic [ADDR_W-1:0] IACK_OFS  = 24'hF00000
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           req_valid,
  input  logic                           req_write,
  input  logic [ADDR_W-1:0]              req_addr,
  input  logic [$clog2(DATA_W/8)-1:0]    req_size,
  input  logic [DATA_W-1:0]              req_wdata,
  output logic                           rsp_valid,
  output logic [DATA_W-1:0]              rsp_rdata,
  output logic                           rsp_unimpl,
  output logic                           caddr_wr,
  output logic                           caddr_rd,
  output logic                           cdata_wr,
  output logic                           cdata_rd,
  output logic [DATA_W/8-1:0]            tgt_be,
  output logic [DATA_W-1:0]              tgt_wdata,
  input  logic [DATA_W-1:0]              caddr_rdata,
  input  logic [DATA_W-1:0]              cdata_rdata,
  output logic                           iack_rd,
  input  logic [VEC_W-1:0]               iack_vec,
  input  logic [(NUM_EXP+2)*4-1:0]       irq_req,
  output logic [3:0]                     irq_line
);

  localparam int unsigned BYTES  = DATA_W / 8;
  localparam int unsigned LANE_W = $clog2(BYTES);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_int = rst_pipe[1];

  tgt_e              tgt;
  logic [BYTES-1:0]  be;
  logic [DATA_W-1:0] bus_wdata;
  logic [DATA_W-1:0] rd_data;

  hostbr_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .CADDR_OFS(CADDR_OFS), .CDATA_OFS(CDATA_OFS), .IACK_OFS(IACK_OFS)
  ) u_decode (
    .clk(clk), .rst_n(rst_n_int),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size),
    .tgt(tgt), .be(be)
  );

  hostbr_lanes #(.DATA_W(DATA_W), .VEC_W(VEC_W)) u_lanes (
    .tgt(tgt), .req_write(req_write),
    .lane(req_addr[LANE_W-1:0]), .req_size(req_size),
    .req_wdata(req_wdata),
    .caddr_rdata(caddr_rdata), .cdata_rdata(cdata_rdata),
    .iack_vec(iack_vec),
    .bus_wdata(bus_wdata), .rd_data(rd_data)
  );

  hostbr_irqmap #(
    .NUM_EXP(NUM_EXP), .FIRST_EXP_SLOT(FIRST_EXP_SLOT),
    .FIXED_SLOT(6), .PASS_SLOT(7), .FIXED_LINE(3), .PINS(4), .LINES(4)
  ) u_irqmap (
    .clk(clk), .rst_n(rst_n_int),
    .irq_req(irq_req), .irq_line(irq_line)
  );

  // Target strobes
  always_comb begin
    caddr_wr  = req_valid &&  req_write && (tgt == TGT_CADDR);
    caddr_rd  = req_valid && !req_write && (tgt == TGT_CADDR);
    cdata_wr  = req_valid &&  req_write && (tgt == TGT_CDATA);
    cdata_rd  = req_valid && !req_write && (tgt == TGT_CDATA);
    iack_rd   = req_valid && (tgt == TGT_IACK);
    tgt_be    = be;
    tgt_wdata = bus_wdata;
  end

  // Response: next state
  logic              rsp_valid_d;
  logic              rsp_en;
  logic [DATA_W-1:0] rsp_rdata_d;
  logic              rsp_unimpl_d;

  always_comb begin
    rsp_valid_d  = req_valid;
    rsp_en       = req_valid;
    rsp_rdata_d  = rd_data;
    rsp_unimpl_d = (tgt == TGT_NONE);
  end

  // Response: registers
  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
      rsp_unimpl <= 1'b0;
    end else begin
      rsp_valid <= rsp_valid_d;
      if (rsp_en) begin
        rsp_rdata  <= rsp_rdata_d;
        rsp_unimpl <= rsp_unimpl_d;
      end
    end
  end

  // R5: one target at most per cycle
  p_single_target_r5: assert property (@(posedge clk) disable iff (!rst_n_int)
    $onehot0({caddr_wr, caddr_rd, cdata_wr, cdata_rd, iack_rd}));

  // R7: response follows request by one cycle
  p_rsp_follows_r7: assert property (@(posedge clk) disable iff (!rst_n_int)
    req_valid |=> rsp_valid);

  p_rsp_idle_r7: assert property (@(posedge clk) disable iff (!rst_n_int)
    !req_valid |=> !rsp_valid);

  // R5: a read that strobes nothing answers all ones and is flagged
  p_unimpl_ones_r5: assert property (@(posedge clk) disable iff (!rst_n_int)
    (req_valid && !req_write && !(caddr_rd || cdata_rd || iack_rd))
      |=> (rsp_unimpl && rsp_rdata == '1));

  // R4: acknowledge is never a write
  p_iack_read_only_r4: assert property (@(posedge clk) disable iff (!rst_n_int)
    iack_rd |-> !req_write);

endmodule

// File: tb/tb_hostbr_regdec.sv
`timescale 1ns/1ps
module tb_hostbr_regdec;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_write;
  logic [23:0] req_addr;
  logic [1:0]  req_size;
  logic [31:0] req_wdata;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        rsp_unimpl;
  logic        caddr_wr, caddr_rd, cdata_wr, cdata_rd, iack_rd;
  logic [3:0]  tgt_be;
  logic [31:0] tgt_wdata;
  logic [31:0] m_caddr, m_cdata;
  logic [7:0]  iack_vec;
  logic [19:0] irq_req;
  logic [3:0]  irq_line;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  hostbr_regdec dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_unimpl(rsp_unimpl),
    .caddr_wr(caddr_wr), .caddr_rd(caddr_rd),
    .cdata_wr(cdata_wr), .cdata_rd(cdata_rd),
    .tgt_be(tgt_be), .tgt_wdata(tgt_wdata),
    .caddr_rdata(m_caddr), .cdata_rdata(m_cdata),
    .iack_rd(iack_rd), .iack_vec(iack_vec),
    .irq_req(irq_req), .irq_line(irq_line)
  );

  // Target models, driven only by the design's strobes
  always @(posedge clk) begin
    for (int b = 0; b < 4; b++) begin
      if (caddr_wr && tgt_be[b]) m_caddr[b*8 +: 8] <= tgt_wdata[b*8 +: 8];
      if (cdata_wr && tgt_be[b]) m_cdata[b*8 +: 8] <= tgt_wdata[b*8 +: 8];
    end
  end

  // Bench-side expectations
  logic [31:0] sh_caddr, sh_cdata;

  function automatic logic [31:0] size_mask(input logic [1:0] sz);
    logic [31:0] m;
    for (int b = 0; b < 4; b++) m[b*8 +: 8] = (b <= sz) ? 8'hFF : 8'h00;
    return m;
  endfunction

  // 0 none, 1 address reg, 2 data port, 3 acknowledge
  function automatic int classify(input logic wr, input logic [23:0] a,
                                  input logic [1:0] sz);
    if (a == 24'hC00CF8) return 1;
    if ((a & 24'hFFFFFC) == 24'hE00CFC && (int'(a[1:0]) + int'(sz) <= 3)) return 2;
    if (a == 24'hF00000 && !wr) return 3;
    return 0;
  endfunction

  function automatic logic [3:0] exp_lines(input logic [19:0] r);
    logic [3:0] l = '0;
    for (int d = 0; d < 5; d++) begin
      for (int p = 0; p < 4; p++) begin
        if (r[d*4+p]) begin
          int slot = (d == 0) ? 6 : (d == 1) ? 7 : 8 + d - 2;
          int line = (d == 0) ? 3 : (d == 1) ? p : (slot + p) % 4;
          l[line] = 1'b1;
        end
      end
    end
    return l;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [23:0] a,
                        input logic [1:0] sz, input logic [31:0] wd,
                        input logic [19:0] irq);
    int cls;
    string tag;
    logic [4:0]  exp_strb;
    logic [3:0]  exp_be;
    logic [31:0] exp_rd;
    logic [31:0] m;
    int lane;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz;
    req_wdata = wd; irq_req = irq; iack_vec = 8'($urandom);
    #1;
    cls  = classify(wr, a, sz);
    lane = int'(a[1:0]);
    m    = size_mask(sz);
    tag  = (cls == 1) ? "R1" : (cls == 2) ? "R2" : (cls == 3) ? "R4" :
           ((a & 24'hFFFFFC) == 24'hE00CFC) ? "R3" : "R5";
    exp_strb = {cls == 1 && wr, cls == 1 && !wr, cls == 2 && wr,
                cls == 2 && !wr, cls == 3};
    chk({caddr_wr, caddr_rd, cdata_wr, cdata_rd, iack_rd} == exp_strb,
        tag, "strobes", 32'({caddr_wr, caddr_rd, cdata_wr, cdata_rd, iack_rd}),
        32'(exp_strb));
    if (cls == 2) begin
      exp_be = 4'(((1 << (int'(sz) + 1)) - 1) << lane);
      chk(tgt_be == exp_be, "R2", "byte enables", 32'(tgt_be), 32'(exp_be));
    end else if (cls == 1) begin
      exp_be = 4'((1 << (int'(sz) + 1)) - 1);
      chk(tgt_be == exp_be, "R1", "byte enables", 32'(tgt_be), 32'(exp_be));
    end
    case (cls)
      1:       exp_rd = sh_caddr & m;
      2:       exp_rd = (sh_cdata >> (lane * 8)) & m;
      3:       exp_rd = {24'h0, iack_vec} & m;
      default: exp_rd = 32'hFFFF_FFFF;
    endcase
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid === 1'b1, "R7", "response valid", 32'(rsp_valid), 32'd1);
    chk(rsp_unimpl === (cls == 0), tag, "unimpl flag", 32'(rsp_unimpl),
        32'(cls == 0));
    chk(irq_line === exp_lines(irq), "R9", "lines during access",
        32'(irq_line), 32'(exp_lines(irq)));
    if (!wr) begin
      chk(rsp_rdata === exp_rd, (cls != 0 && sz != 3) ? "R6" : tag,
          "read data", rsp_rdata, exp_rd);
    end else begin
      for (int k = 0; k <= int'(sz); k++) begin
        if (cls == 1) sh_caddr[k*8 +: 8] = wd[k*8 +: 8];
        if (cls == 2) sh_cdata[(lane+k)*8 +: 8] = wd[k*8 +: 8];
      end
      chk(m_caddr === sh_caddr, (cls == 1) ? "R1" : "R5", "address reg",
          m_caddr, sh_caddr);
      chk(m_cdata === sh_cdata, (cls == 2) ? "R6" : tag, "data port",
          m_cdata, sh_cdata);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
    req_size = '0; req_wdata = '0; iack_vec = '0; irq_req = '0;
    m_caddr = '0; m_cdata = '0; sh_caddr = '0; sh_cdata = '0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(rsp_valid === 1'b0, "R10", "rsp_valid", 32'(rsp_valid), 0);
    chk(rsp_rdata === 32'h0, "R10", "rsp_rdata", rsp_rdata, 0);
    chk(rsp_unimpl === 1'b0, "R10", "rsp_unimpl", 32'(rsp_unimpl), 0);
    chk(irq_line === 4'h0, "R10", "irq_line", 32'(irq_line), 0);

    // Directed corner cases
    access(1, 24'hC00CF8, 2'd3, 32'hA1B2C3D4, '0);   // R1 full write
    access(0, 24'hC00CF8, 2'd0, 32'h0, '0);          // R6 narrow read
    access(0, 24'hC00CF9, 2'd0, 32'h0, '0);          // R1 off-by-one
    access(1, 24'hC00CFA, 2'd1, 32'h1234, '0);       // R5 dropped write
    access(1, 24'hE00CFC, 2'd3, 32'h11223344, '0);   // R2
    access(1, 24'hE00CFF, 2'd0, 32'hFFFFFF99, '0);   // R2 top lane, R6
    access(1, 24'hE00CFD, 2'd1, 32'h0000BEEF, '0);   // R2 middle
    access(0, 24'hE00CFE, 2'd1, 32'h0, '0);          // R2 read
    access(0, 24'hE00CFD, 2'd2, 32'h0, '0);          // R2 exact fit
    access(0, 24'hE00CFE, 2'd3, 32'h0, '0);          // R3 overrun read
    access(1, 24'hE00CFF, 2'd1, 32'h5555, '0);       // R3 overrun write
    access(0, 24'hF00000, 2'd3, 32'h0, '0);          // R4
    access(1, 24'hF00000, 2'd0, 32'h77, '0);         // R4 write ignored
    access(0, 24'h000010, 2'd3, 32'h0, '0);          // R5
    // R7 pulse ends after one cycle
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R7", "single-cycle pulse", 32'(rsp_valid), 0);

    // R8 each pin of each position alone
    for (int i = 0; i < 20; i++) begin
      @(negedge clk) irq_req = 20'(1) << i;
      @(negedge clk);
      chk(irq_line === exp_lines(irq_req), "R8", "single route",
          32'(irq_line), 32'(exp_lines(irq_req)));
    end

    // Random accesses with simultaneous request changes
    for (int n = 0; n < 500; n++) begin
      logic [23:0] a;
      int sel = $urandom % 8;
      case (sel)
        0:       a = 24'hC00CF8;
        1:       a = 24'hC00CF8 + 24'(1 + $urandom % 3);
        2, 3:    a = 24'hE00CFC + 24'($urandom % 4);
        4:       a = 24'hF00000;
        5:       a = 24'hF00000 + 24'(1 + $urandom % 4);
        6:       a = 24'($urandom);
        default: a = 24'hE00CF8 + 24'($urandom % 4);
      endcase
      access(1'($urandom), a, 2'($urandom), $urandom,
             20'($urandom) & 20'($urandom));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule